// File: doc/BRIEF.md
# Pin Event Flag and Request Generator

This block watches a bank of already filtered pin inputs. Each pin has a 4-bit mode code that picks the condition it responds to: a rising edge, a falling edge, either edge, a low level or a high level. The code also sends the event either to the DMA request path or to the interrupt path. When the condition is met, the pin's sticky flag is set. The block drives one interrupt line for the whole port and one DMA request line for the whole port.

Flags can be cleared in three ways. Software can clear a single pin by index. Software can clear any set of pins at once with a write-one-to-clear mask. A DMA-complete pulse clears every flag whose pin is in a DMA mode. A level-mode pin whose level is still present after a clear sets its flag again on the same edge, so the request is never lost.

Top module: `pin_event_detect`

## Requirements
- R1: After reset all flags, `irq` and `dma_req` are 0. No edge is detected on the first clock after reset, whatever level the pins hold.
- R2: Codes 1, 2 and 3 set a pin's flag on a rising, falling or either edge. An edge is the pin value differing from its value one clock earlier. The flag is visible one clock after the changed input is sampled. `dma_req` is the OR of the flags of pins whose code is 1, 2 or 3.
- R3: Codes 9, 10 and 11 set the flag on a rising, falling or either edge. `irq` is the OR of the flags of pins whose code is 8 to 12.
- R4: Code 8 sets the flag on every clock while the pin is 0. Code 12 sets it on every clock while the pin is 1.
- R5: A set flag holds until one of the clear sources below removes it.
- R6: With `pin_clr_en` high, the flag of the pin numbered `pin_clr_idx` is cleared and no other flag changes.
- R7: With `port_clr_en` high, every flag whose bit in `port_clr_mask` is 1 is cleared. Flags whose mask bit is 0 are kept.
- R8: A `dma_done` pulse clears the flags of pins with codes 1 to 3 only. Flags of interrupt-mode pins stay set.
- R9: When a pin's set condition and a clear hit in the same clock, the flag ends up set. A level-mode pin whose level is still active therefore keeps its flag after a clear.
- R10: Codes 0, 4 to 7 and 13 to 15 never set a flag. Pins with these codes add nothing to `irq` or `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Filtered pin levels |
| pin_cfg | input | 4*NPINS | Mode code per pin; pin i uses bits 4i+3:4i |
| pin_clr_en | input | 1 | Clear the flag of one pin |
| pin_clr_idx | input | IW | Pin number for the single-pin clear |
| port_clr_en | input | 1 | Apply the write-one-to-clear mask |
| port_clr_mask | input | NPINS | Flags to clear, one bit per pin |
| dma_done | input | 1 | DMA transfer complete; clears the DMA-mode flags |
| flags | output | NPINS | Sticky per-pin event flags |
| irq | output | 1 | Port interrupt request |
| dma_req | output | 1 | Port DMA request |

## Verification
Every flag result comes out of a single register stage. An input change, clear or `dma_done` applied before a clock edge shows up in `flags` right after that edge. `irq` and `dma_req` follow `flags` and `pin_cfg` combinationally in the same cycle. The bench drives all stimulus just after a falling edge. It then waits for exactly one further falling edge before it compares, so each check falls in the first cycle the result is due. Hold checks wait extra cycles to confirm that nothing drifts.

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
  parameter int NPINS = 32,
  localparam int IW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pin_in,
  input  logic [4*NPINS-1:0]   pin_cfg,
  input  logic                 pin_clr_en,
  input  logic [IW-1:0]        pin_clr_idx,
  input  logic                 port_clr_en,
  input  logic [NPINS-1:0]     port_clr_mask,
  input  logic                 dma_done,
  output logic [NPINS-1:0]     flags,
  output logic                 irq,
  output logic                 dma_req
);

  logic [NPINS-1:0] prev;
  logic             armed;
  logic [NPINS-1:0] rise, fall, ev, clr, dma_sel, int_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev  <= '0;
      armed <= 1'b0;
    end else begin
      prev  <= pin_in;
      armed <= 1'b1;
    end

  assign rise = {NPINS{armed}} & pin_in & ~prev;
  assign fall = {NPINS{armed}} & ~pin_in & prev;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [3:0] code;
    assign code = pin_cfg[4*i +: 4];

    always_comb begin
      ev[i]      = 1'b0;
      dma_sel[i] = 1'b0;
      int_sel[i] = 1'b0;
      case (code)
        4'd1:  begin dma_sel[i] = 1'b1; ev[i] = rise[i]; end
        4'd2:  begin dma_sel[i] = 1'b1; ev[i] = fall[i]; end
        4'd3:  begin dma_sel[i] = 1'b1; ev[i] = rise[i] | fall[i]; end
        4'd8:  begin int_sel[i] = 1'b1; ev[i] = ~pin_in[i]; end
        4'd9:  begin int_sel[i] = 1'b1; ev[i] = rise[i]; end
        4'd10: begin int_sel[i] = 1'b1; ev[i] = fall[i]; end
        4'd11: begin int_sel[i] = 1'b1; ev[i] = rise[i] | fall[i]; end
        4'd12: begin int_sel[i] = 1'b1; ev[i] = pin_in[i]; end
        default: ;
      endcase
    end

    assign clr[i] = (port_clr_en & port_clr_mask[i])
                  | (pin_clr_en & (pin_clr_idx == IW'(i)))
                  | (dma_done & dma_sel[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] & ~clr[i]) | ev[i];

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !port_clr_en && !pin_clr_en && !dma_done) |=> flags[i]);

    // R9
    level_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_clr_en && port_clr_mask[i] && code == 4'd8 && !pin_in[i]) |=> flags[i]);

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[i] && (code == 4'd0 || code == 4'd5 || code == 4'd6 || code == 4'd7 ||
                     code == 4'd13 || code == 4'd15)) |=> !flags[i]);

    // R8
    dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done && code >= 4'd1 && code <= 4'd3 && pin_in[i] == prev[i]) |=> !flags[i]);
  end

  assign irq     = |(flags & int_sel);
  assign dma_req = |(flags & dma_sel);

  // R2
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flags) |-> (!irq && !dma_req));

endmodule

// File: tb/tb_pin_event_detect.sv
module tb_pin_event_detect;
  localparam int N = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [4*N-1:0] pin_cfg = '0;
  logic pin_clr_en = 1'b0;
  logic [IW-1:0] pin_clr_idx = '0;
  logic port_clr_en = 1'b0;
  logic [N-1:0] port_clr_mask = '0;
  logic dma_done = 1'b0;
  logic [N-1:0] flags;
  logic irq, dma_req;
  int checks = 0;
  int errors = 0;

  pin_event_detect #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_cfg(pin_cfg),
    .pin_clr_en(pin_clr_en), .pin_clr_idx(pin_clr_idx),
    .port_clr_en(port_clr_en), .port_clr_mask(port_clr_mask),
    .dma_done(dma_done), .flags(flags), .irq(irq), .dma_req(dma_req));

  always #2 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setcfg(int pin, logic [3:0] code);
    pin_cfg[4*pin +: 4] = code;
  endtask

  task automatic clean();
    pin_cfg = '0; pin_in = '0; pin_clr_en = 0; dma_done = 0;
    port_clr_en = 1; port_clr_mask = '1;
    tick();
    port_clr_en = 0; port_clr_mask = '0;
    tick();
  endtask

  task automatic t_reset();
    pin_in = 32'h1; setcfg(0, 4'd1);
    #1 rst_n = 1'b0;
    tick(); tick();
    check("R1 flags in reset", flags, 0);
    check("R1 outputs in reset", {irq, dma_req}, 0);
    rst_n = 1'b1;
    tick(); tick();
    check("R1 no edge after reset", flags, 0);
    check("R1 dma_req after reset", dma_req, 0);
  endtask

  task automatic t_dma_edges();
    clean();
    setcfg(3, 4'd1); setcfg(4, 4'd2); setcfg(5, 4'd3);
    tick();
    pin_in[5:3] = 3'b111; tick();
    check("R2 rise on codes 1,3", flags, 32'h28);
    check("R2 dma_req/irq", {dma_req, irq}, 2'b10);
    pin_in[5:3] = 3'b000; tick();
    check("R2 fall on code 2", flags, 32'h38);
    tick(); tick();
    check("R5 flags held", flags, 32'h38);
  endtask

  task automatic t_int_edges();
    clean();
    setcfg(7, 4'd9); setcfg(8, 4'd10); setcfg(9, 4'd11);
    tick();
    check("R3 idle", {flags[9:7], irq}, 0);
    pin_in[9:7] = 3'b111; tick();
    check("R3 rise on codes 9,11", flags, 32'h280);
    check("R3 irq/dma_req", {irq, dma_req}, 2'b10);
    pin_in[9:7] = 3'b000; tick();
    check("R3 fall on code 10", flags, 32'h380);
  endtask

  task automatic t_levels();
    clean();
    pin_in[11] = 1'b1; tick();
    setcfg(10, 4'd8); setcfg(11, 4'd12); tick();
    check("R4 level low/high", flags, 32'hC00);
    check("R4 irq", irq, 1);
    pin_clr_en = 1; pin_clr_idx = 5'd10; tick();
    pin_clr_en = 0;
    check("R9 level low re-sets after clear", flags[10], 1);
    pin_in[10] = 1'b1; tick();
    pin_clr_en = 1; pin_clr_idx = 5'd10; tick();
    pin_clr_en = 0;
    check("R4 level gone then cleared", flags, 32'h800);
  endtask

  task automatic t_unused();
    clean();
    setcfg(12, 4'd0); setcfg(13, 4'd5); setcfg(14, 4'd14); setcfg(15, 4'd7);
    tick();
    pin_in[15:12] = 4'hF; tick();
    pin_in[15:12] = 4'h0; tick();
    check("R10 unused codes set nothing", flags, 0);
    check("R10 no outputs", {irq, dma_req}, 0);
  endtask

  task automatic t_pin_clear();
    clean();
    setcfg(3, 4'd1); setcfg(7, 4'd9); tick();
    pin_in[3] = 1; pin_in[7] = 1; tick();
    check("R6 setup", flags, 32'h88);
    pin_clr_en = 1; pin_clr_idx = 5'd3; tick();
    pin_clr_en = 0;
    check("R6 single pin cleared", flags, 32'h80);
    check("R6 dma_req dropped", {dma_req, irq}, 2'b01);
  endtask

  task automatic t_port_clear();
    clean();
    setcfg(1, 4'd1); setcfg(2, 4'd9); setcfg(20, 4'd3); setcfg(31, 4'd11); tick();
    pin_in[1] = 1; pin_in[2] = 1; pin_in[20] = 1; pin_in[31] = 1; tick();
    check("R7 setup", flags, 32'h8010_0006);
    port_clr_en = 1; port_clr_mask = 32'h8000_0002; tick();
    port_clr_en = 0; port_clr_mask = '0;
    check("R7 masked clear", flags, 32'h0010_0004);
  endtask

  task automatic t_dma_done();
    clean();
    setcfg(3, 4'd1); setcfg(7, 4'd9); tick();
    pin_in[3] = 1; pin_in[7] = 1; tick();
    dma_done = 1; tick();
    dma_done = 0;
    check("R8 dma_done clears only DMA pins", flags, 32'h80);
    check("R8 outputs", {dma_req, irq}, 2'b01);
  endtask

  task automatic t_set_wins();
    clean();
    setcfg(3, 4'd1); tick();
    pin_in[3] = 1; tick();
    pin_in[3] = 0; tick();
    pin_in[3] = 1; pin_clr_en = 1; pin_clr_idx = 5'd3; tick();
    pin_clr_en = 0;
    check("R9 set wins over clear", flags[3], 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_dma_edges();
    t_int_edges();
    t_levels();
    t_unused();
    t_pin_clear();
    t_port_clear();
    t_dma_done();
    t_set_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule